// File: doc/BRIEF.md
# Full-Cycle Pseudo-Random Shift Counter

This block is a parameterised Fibonacci shift register that acts as a pseudo-random counter. On each enabled clock edge the stages move one place toward the most significant end. The new least significant bit is the XOR parity of the stages selected by a tap mask. With the default 8-stage mask the register walks through every non-zero value once before it repeats.

A sequence-select input is sampled only while reset is held. When it is 0 the block produces the usual maximal-length cycle of 2^N−1 states. When it is 1, a correction term is folded into the feedback so that the all-zero value is added to the cycle and every one of the 2^N values is visited. In the maximal-length cycle, a zero state is never a dead end: the next value is forced to a non-zero recovery value. A single-bit serial output follows one chosen stage. Width, tap mask, reset seed, reset level and serial stage are compile-time parameters.

Top module: `lfsr_fullcycle`

## Requirements
- R1: On every rising clock edge while reset is at its active level, the state is loaded with SEED (default 8'hFF) and the sequence-select input is captured.
- R2: With reset inactive and `step_en` low, the state does not change.
- R3: In maximal-length mode (captured select = 0) with a non-zero state, the next state is the state shifted up by one bit, and bit 0 takes the XOR of state bits 7, 5, 4 and 3 (default mask 8'hB8).
- R4: In maximal-length mode, starting from the seed 8'hFF, the state returns to the seed after exactly 255 enabled steps. No value repeats before that and the value zero never appears.
- R5: In full-cycle mode (captured select = 1), bit 0 also gets an XOR with 1 whenever bits 6..0 are all zero. As a result 8'h80 steps to 8'h00 and 8'h00 steps to 8'h01. The period from the seed is exactly 256 steps, and every value, zero included, appears exactly once.
- R6: Changes on the sequence-select input while reset is inactive have no effect on the sequence being produced.
- R7: `ser_bit` always equals the state bit at index SER_TAP (default 0).
- R8: In maximal-length mode, a zero state steps to SEED. If SEED is itself zero, it steps to all ones instead.
- R9: When RST_ACTIVE is 0, reset is applied while `rst` is low and released while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset; its active level is set by RST_ACTIVE |
| step_en | input | 1 | Advances the state when high; holds it when low |
| full_cycle | input | 1 | Sequence select, captured during reset: 0 = 2^N−1 cycle, 1 = 2^N cycle |
| state | output | WIDTH | Parallel register contents |
| ser_bit | output | 1 | Register stage number SER_TAP |

## Verification
The assertions assume that reset is held for at least one rising edge before any step is checked. They also assume that the tap mask includes the top stage, so the shift/feedback relations hold. The stepping assertions are disabled during reset cycles. The bench meets these assumptions by starting each instance in reset at time zero and changing inputs only just after a clock edge. It also toggles the sequence select only while reset is released, which exercises the ignored-input case without breaking the sampling rule.

// File: rtl/lfsr_fc_pkg.sv
package lfsr_fc_pkg;

    typedef enum logic {
        SEQ_MAXLEN = 1'b0,
        SEQ_FULL   = 1'b1
    } seq_mode_e;

    // Feedback terms produced by the combinational step logic
    typedef struct packed {
        logic parity_fb;   // XOR of tapped stages
        logic lower_zero;  // all stages below the top are zero
        logic all_zero;    // whole register is zero
    } fb_terms_t;

    function automatic seq_mode_e decode_mode(input logic sel);
        return sel ? SEQ_FULL : SEQ_MAXLEN;
    endfunction

endpackage

// File: rtl/lfsr_fc_mode_reg.sv
module lfsr_fc_mode_reg
    import lfsr_fc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_act,
    input  logic      sel_in,
    output seq_mode_e mode_q
);

    // Captured only during reset so the sequence cannot switch mid-run
    always_ff @(posedge clk) begin
        if (rst_act) begin
            mode_q <= decode_mode(sel_in);
        end
    end

endmodule

// File: rtl/lfsr_fc_feedback.sv
module lfsr_fc_feedback
    import lfsr_fc_pkg::*;
#(
    parameter int                 WIDTH    = 8,
    parameter logic [WIDTH-1:0]   TAP_MASK = 'hB8,
    parameter logic [WIDTH-1:0]   RECOVER  = '1
) (
    input  logic [WIDTH-1:0] cur,
    input  seq_mode_e        mode,
    output logic [WIDTH-1:0] nxt
);

    localparam int LOW_W = WIDTH - 1;

    fb_terms_t        terms;
    logic [WIDTH-1:0] tapped;
    logic             new_bit;

    assign tapped = cur & TAP_MASK;

    always_comb begin
        terms.parity_fb  = ^tapped;
        terms.lower_zero = ~|cur[LOW_W-1:0];
        terms.all_zero   = terms.lower_zero & ~cur[WIDTH-1];
    end

    always_comb begin
        new_bit = terms.parity_fb;
        if (mode == SEQ_FULL) begin
            new_bit = terms.parity_fb ^ terms.lower_zero;
        end
    end

    always_comb begin
        if (mode == SEQ_MAXLEN && terms.all_zero) begin
            nxt = RECOVER;
        end else begin
            nxt = {cur[LOW_W-1:0], new_bit};
        end
    end

endmodule

// File: rtl/lfsr_fc_state_reg.sv
module lfsr_fc_state_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_act,
    input  logic             step_en,
    input  logic [WIDTH-1:0] seed,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst_act) begin
            q <= seed;
        end else if (step_en) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/lfsr_fullcycle.sv
module lfsr_fullcycle
    import lfsr_fc_pkg::*;
#(
    parameter int               WIDTH      = 8,
    parameter logic [WIDTH-1:0] TAP_MASK   = 'hB8,
    parameter logic [WIDTH-1:0] SEED       = '1,
    parameter logic             RST_ACTIVE = 1'b1,
    parameter int               SER_TAP    = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             full_cycle,
    output logic [WIDTH-1:0] state,
    output logic             ser_bit
);

    localparam logic [WIDTH-1:0] SEED_V    = SEED;
    localparam logic [WIDTH-1:0] RECOVER_V = (SEED != '0) ? SEED : '1;

    logic             rst_act;
    seq_mode_e        mode_q;
    logic [WIDTH-1:0] nxt;

    assign rst_act = (rst == RST_ACTIVE);

    lfsr_fc_mode_reg u_mode (
        .clk     (clk),
        .rst_act (rst_act),
        .sel_in  (full_cycle),
        .mode_q  (mode_q)
    );

    lfsr_fc_feedback #(
        .WIDTH    (WIDTH),
        .TAP_MASK (TAP_MASK),
        .RECOVER  (RECOVER_V)
    ) u_fb (
        .cur  (state),
        .mode (mode_q),
        .nxt  (nxt)
    );

    lfsr_fc_state_reg #(
        .WIDTH (WIDTH)
    ) u_reg (
        .clk     (clk),
        .rst_act (rst_act),
        .step_en (step_en),
        .seed    (SEED_V),
        .nxt     (nxt),
        .q       (state)
    );

    generate
        if (SER_TAP >= 0 && SER_TAP < WIDTH) begin : g_ser
            assign ser_bit = state[SER_TAP];
        end else begin : g_ser_clamp
            assign ser_bit = state[0];
        end
    endgenerate

endmodule

// File: rtl/lfsr_fc_chk.sv
module lfsr_fc_chk #(
    parameter int               WIDTH   = 8,
    parameter logic [WIDTH-1:0] SEED    = '1,
    parameter logic [WIDTH-1:0] RECOVER = '1
) (
    input logic             clk,
    input logic             rst_act,
    input logic             step_en,
    input logic             sel_in,
    input logic             mode_q,
    input logic [WIDTH-1:0] state
);

    localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ONE_V    = {{(WIDTH-1){1'b0}}, 1'b1};

    assert_reset_seed_R1: assert property (@(posedge clk)
        rst_act |=> state == SEED);

    assert_reset_mode_R1: assert property (@(posedge clk)
        rst_act |=> mode_q == $past(sel_in));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst_act)
        !step_en |=> state == $past(state));

    assert_shift_R3: assert property (@(posedge clk) disable iff (rst_act)
        (step_en && !mode_q && state != '0) |=> state[WIDTH-1:1] == $past(state[WIDTH-2:0]));

    assert_no_zero_R4: assert property (@(posedge clk) disable iff (rst_act)
        (step_en && !mode_q && state != '0) |=> state != '0);

    assert_enter_zero_R5: assert property (@(posedge clk) disable iff (rst_act)
        (step_en && mode_q && state == TOP_ONLY) |=> state == '0);

    assert_leave_zero_R5: assert property (@(posedge clk) disable iff (rst_act)
        (step_en && mode_q && state == '0) |=> state == ONE_V);

    assert_mode_ignored_R6: assert property (@(posedge clk) disable iff (rst_act)
        (sel_in != mode_q) |=> mode_q == $past(mode_q));

    assert_recover_R8: assert property (@(posedge clk) disable iff (rst_act)
        (step_en && !mode_q && state == '0) |=> state == RECOVER);

endmodule

bind lfsr_fullcycle lfsr_fc_chk #(
    .WIDTH   (WIDTH),
    .SEED    (SEED_V),
    .RECOVER (RECOVER_V)
) u_chk (
    .clk     (clk),
    .rst_act (rst_act),
    .step_en (step_en),
    .sel_in  (full_cycle),
    .mode_q  (mode_q),
    .state   (state)
);

// File: tb/sim_lfsr_fullcycle.sv
`timescale 1ns/1ps
module sim_lfsr_fullcycle;

    logic       clk = 1'b0;
    logic       rst, en, ext;
    logic [7:0] st0;
    logic       ser0;
    logic       rst1_n, en1, ext1;
    logic [7:0] st1;
    logic       ser1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    lfsr_fullcycle u0 (
        .clk(clk), .rst(rst), .step_en(en), .full_cycle(ext),
        .state(st0), .ser_bit(ser0)
    );

    lfsr_fullcycle #(
        .WIDTH(8), .TAP_MASK(8'hB8), .SEED(8'h00), .RST_ACTIVE(1'b0), .SER_TAP(7)
    ) u1 (
        .clk(clk), .rst(rst1_n), .step_en(en1), .full_cycle(ext1),
        .state(st1), .ser_bit(ser1)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_next(input logic [7:0] s, input bit full);
        logic fb;
        fb = ^(s & 8'hB8);
        if (full) fb = fb ^ (s[6:0] == 7'd0);
        if (!full && s == 8'h00) return 8'hFF;
        return {s[6:0], fb};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // R1: seed load and mode capture; select flipped afterwards (R6)
    task automatic test_reset(input bit m);
        rst = 1'b1; en = 1'b1; ext = m;
        tick();
        chk(st0 == 8'hFF, "R1 seed load", st0, 8'hFF);
        tick();
        chk(st0 == 8'hFF, "R1 seed held in reset", st0, 8'hFF);
        chk(ser0 == st0[0], "R7 serial tap 0", ser0, st0[0]);
        rst = 1'b0; ext = ~m;
    endtask

    task automatic test_period(input bit m);
        bit         seen [256];
        logic [7:0] exp;
        int         period, step_err, rep_err, zeros, ser_err;
        for (int i = 0; i < 256; i++) seen[i] = 1'b0;
        exp = 8'hFF; seen[8'hFF] = 1'b1;
        period = 0; step_err = 0; rep_err = 0; zeros = 0; ser_err = 0;
        for (int k = 1; k <= 300; k++) begin
            tick();
            exp = model_next(exp, m);
            if (st0 != exp) begin
                if (step_err == 0) $display("step %0d: state %0h model %0h", k, st0, exp);
                step_err++;
            end
            if (ser0 != st0[0]) ser_err++;
            if (st0 == 8'h00) zeros++;
            if (st0 == 8'hFF) begin
                period = k;
                break;
            end
            if (seen[st0]) rep_err++;
            seen[st0] = 1'b1;
        end
        if (m) begin
            chk(step_err == 0, "R5 full-cycle step rule", step_err, 0);
            chk(period == 256, "R5 full-cycle period", period, 256);
            chk(zeros == 1, "R5 zero visited once", zeros, 1);
            chk(rep_err == 0, "R5 no early repeat", rep_err, 0);
            chk(period == 256, "R6 select change ignored (full)", period, 256);
        end else begin
            chk(step_err == 0, "R3 step rule", step_err, 0);
            chk(period == 255, "R4 period", period, 255);
            chk(zeros == 0, "R4 zero never appears", zeros, 0);
            chk(rep_err == 0, "R4 no early repeat", rep_err, 0);
            chk(period == 255, "R6 select change ignored (maxlen)", period, 255);
        end
        chk(ser_err == 0, "R7 serial follows stage", ser_err, 0);
    endtask

    task automatic test_hold();
        logic [7:0] snap;
        tick(); tick();
        en = 1'b0;
        snap = st0;
        for (int i = 0; i < 5; i++) tick();
        chk(st0 == snap, "R2 hold when disabled", st0, snap);
        en = 1'b1;
        tick();
        chk(st0 == model_next(snap, 1'b1), "R2 resume after hold", st0, model_next(snap, 1'b1));
    endtask

    task automatic test_zero_seed();
        rst1_n = 1'b0; en1 = 1'b1; ext1 = 1'b0;
        tick();
        chk(st1 == 8'h00, "R9 active-low reset loads seed", st1, 8'h00);
        chk(ser1 == st1[7], "R7 serial tap 7", ser1, st1[7]);
        rst1_n = 1'b1; ext1 = 1'b1;
        tick();
        chk(st1 == 8'hFF, "R8 zero recovers to all ones", st1, 8'hFF);
        tick();
        chk(st1 == model_next(8'hFF, 1'b0), "R9 released when high", st1, model_next(8'hFF, 1'b0));
        chk(ser1 == st1[7], "R7 serial tap 7 after step", ser1, st1[7]);
    endtask

    initial begin
        rst = 1'b1; en = 1'b0; ext = 1'b0;
        rst1_n = 1'b0; en1 = 1'b0; ext1 = 1'b0;
        tick();
        test_reset(1'b0);
        test_period(1'b0);
        test_reset(1'b1);
        test_period(1'b1);
        test_hold();
        test_zero_seed();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule